// File: doc/BRIEF.md
# Command-Word Watchdog Timer

This block is a watchdog timer driven over a small memory-mapped register bus. Software steers it by writing exact 16-bit command words into a control register. The words stop or resume the countdown, open or close write access to the count, acknowledge the interrupt, or reload the countdown to its ceiling. Any other word has no effect.

A second register exposes the upper sixteen bits of a 20-bit down-counter. The counter steps once for every pulse on a timer tick-enable input. When it runs out, the block raises a sticky interrupt flag and a reset request for the system reset controller.

A forced restart works like this: software unlocks the count register, writes a count of one, locks it again and resumes the countdown. Expiry then follows within sixteen ticks.

Top module: `cmd_watchdog`

## Requirements
- R1: After reset the counter holds 0xFFFF0 (a count-register read returns 0xFFFF), the countdown is stopped, the count register is write-locked, and both `irq` and `rst_req` are low.
- R2: The control register is at byte offset 0x0 and the count register is at byte offset 0x4. A read of 0x4 returns counter bits 19:4 in `bus_rdata[15:0]`, with the upper bits zero. A read of 0x0 returns zero. Reads never change any state.
- R3: Only the low 16 bits of a control write are decoded, and they must equal a command word exactly. The upper 16 bits are ignored, and a word that is not a command has no effect.
- R4: Word 0x3877 stops the countdown and freezes the counter. Word 0x4A4B resumes the countdown from the frozen value.
- R5: Word 0xAB00 opens the count register for writes and word 0xAB01 closes it. A count write made while the register is closed is ignored.
- R6: A count write made while the register is open loads `bus_wdata[15:0]` into counter bits 19:4, clears bits 3:0, and drops `rst_req`.
- R7: Word 0xDEAF sets the counter to 0xFFFF0 and drops `rst_req`. It works whether the count register is open or closed.
- R8: While the countdown runs, each cycle with `tick_en` high lowers the counter by one. While it is stopped, ticks are ignored.
- R9: A tick that takes a running counter to zero (or finds it at zero) sets `irq` and `rst_req`. The counter then stays at zero. A loaded count of 1 expires on exactly the 16th tick.
- R10: `irq` stays set until word 0x7482 clears it. `rst_req` stays set until reset or until the counter is reloaded, and the 0x7482 word does not clear it.
- R11: When a count load and a tick fall in the same cycle, the load wins and the tick is lost. When an expiry and a 0x7482 clear fall in the same cycle, `irq` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per timer tick |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| irq | output | 1 | Sticky expiry interrupt flag |
| rst_req | output | 1 | Reset request to the system reset controller |

## Verification
Two pairs of events can land in the same cycle:
- A bus write to the count register and a timer tick.
- The final expiring tick and a bus write of the interrupt-clear word.

The bench provokes each pair by raising `tick_en` in the very cycle that carries the bus write.

For the first pair, the count read back afterwards must equal the written value with no tick taken off. For the second pair, `irq` and `rst_req` must both be high at the next falling edge, so the expiry is not lost to the clear.

// File: rtl/cmd_watchdog_pkg.sv
// Package: shared constants and types for the command-word watchdog.
// Assumes command words are 16 bits wide and compared exactly.
package cmd_watchdog_pkg;

    localparam int CMD_W = 16;

    localparam logic [CMD_W-1:0] CMD_HALT    = 16'h3877;
    localparam logic [CMD_W-1:0] CMD_RUN     = 16'h4A4B;
    localparam logic [CMD_W-1:0] CMD_ACK     = 16'h7482;
    localparam logic [CMD_W-1:0] CMD_OPEN    = 16'hAB00;
    localparam logic [CMD_W-1:0] CMD_CLOSE   = 16'hAB01;
    localparam logic [CMD_W-1:0] CMD_REFILL  = 16'hDEAF;

    // One-cycle strobes produced by the bus decoder.
    typedef struct packed {
        logic halt;
        logic run;
        logic ack;
        logic open;
        logic close;
        logic refill;
        logic cnt_wr;
    } wdt_cmd_t;

endpackage

// File: rtl/cmd_watchdog_decode.sv
// Module: cmd_watchdog_decode
// Turns one bus write into at most one command strobe.
// Assumes a single access per cycle. Only the low CMD_W data bits are
// compared against the command words; the rest of the word is not looked at.
module cmd_watchdog_decode
    import cmd_watchdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 4'h0,
    parameter logic [ADDR_W-1:0] CNT_OFS  = 4'h4
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CMD_W-1:0]  cmd_word,
    output wdt_cmd_t          cmd
);

    logic ctrl_wr;

    // Purpose: qualify the write strobe for each register and match the command words.
    always_comb begin
        ctrl_wr    = bus_sel && bus_wr && (bus_addr == CTRL_OFS);
        cmd.halt   = ctrl_wr && (cmd_word == CMD_HALT);
        cmd.run    = ctrl_wr && (cmd_word == CMD_RUN);
        cmd.ack    = ctrl_wr && (cmd_word == CMD_ACK);
        cmd.open   = ctrl_wr && (cmd_word == CMD_OPEN);
        cmd.close  = ctrl_wr && (cmd_word == CMD_CLOSE);
        cmd.refill = ctrl_wr && (cmd_word == CMD_REFILL);
        cmd.cnt_wr = bus_sel && bus_wr && (bus_addr == CNT_OFS);
    end

endmodule

// File: rtl/cmd_watchdog_mode.sv
// Module: cmd_watchdog_mode
// Holds the run/stop state and the count-register write gate.
// Assumes command strobes are mutually exclusive (one bus write per cycle).
module cmd_watchdog_mode
    import cmd_watchdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wdt_cmd_t cmd,
    output logic     running,
    output logic     unlocked,
    output logic     load_ok
);

    // Purpose: update the run and write-gate flags from the command strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            unlocked <= 1'b0;
        end else begin
            if (cmd.halt)
                running <= 1'b0;
            else if (cmd.run)
                running <= 1'b1;
            if (cmd.open)
                unlocked <= 1'b1;
            else if (cmd.close)
                unlocked <= 1'b0;
        end
    end

    // Purpose: let a count write through only while the gate is open.
    always_comb load_ok = cmd.cnt_wr && unlocked;

endmodule

// File: rtl/cmd_watchdog_timer.sv
// Module: cmd_watchdog_timer
// Down-counter with expiry flags. A bus load outranks a tick, and an expiry
// outranks an interrupt acknowledge issued in the same cycle.
// Assumes tick is a one-cycle enable pulse.
module cmd_watchdog_timer #(
    parameter int CNT_W  = 20,
    parameter int FRAC_W = 4,
    localparam int REG_W = CNT_W - FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             running,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    input  logic             refill,
    input  logic             ack,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             rst_req
);

    localparam logic [CNT_W-1:0] FULL = {{REG_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic any_load;
    logic step;
    logic expire;

    // Purpose: derive the load, step and expiry conditions for this cycle.
    always_comb begin
        any_load = load || refill;
        step     = running && tick && !any_load;
        expire   = step && (count <= ONE);
    end

    // Purpose: load, refill or decrement the counter, and hold it at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= FULL;
        else if (load)
            count <= {load_val, {FRAC_W{1'b0}}};
        else if (refill)
            count <= FULL;
        else if (step && count != '0)
            count <= count - ONE;
    end

    // Purpose: keep the sticky interrupt; an expiry beats an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (expire)
            irq <= 1'b1;
        else if (ack)
            irq <= 1'b0;
    end

    // Purpose: assert the reset request on expiry and drop it on any reload.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req <= 1'b0;
        else if (expire)
            rst_req <= 1'b1;
        else if (any_load)
            rst_req <= 1'b0;
    end

endmodule

// File: rtl/cmd_watchdog.sv
// Module: cmd_watchdog (top)
// Watchdog with a command-word control register and a write-gated count register.
// Assumes bus_rdata is sampled in the cycle of a read strobe (a combinational read).
module cmd_watchdog
    import cmd_watchdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 20,
    parameter int FRAC_W = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 4'h0,
    parameter logic [ADDR_W-1:0] CNT_OFS  = 4'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    localparam int REG_W = CNT_W - FRAC_W;

    wdt_cmd_t          cmd;
    logic              running;
    logic              unlocked;
    logic              load_ok;
    logic [CNT_W-1:0]  count;

    cmd_watchdog_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .CNT_OFS(CNT_OFS)
    ) u_decode (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .cmd_word(bus_wdata[CMD_W-1:0]),
        .cmd     (cmd)
    );

    cmd_watchdog_mode u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .running (running),
        .unlocked(unlocked),
        .load_ok (load_ok)
    );

    cmd_watchdog_timer #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .running (running),
        .load    (load_ok),
        .load_val(bus_wdata[REG_W-1:0]),
        .refill  (cmd.refill),
        .ack     (cmd.ack),
        .count   (count),
        .irq     (irq),
        .rst_req (rst_req)
    );

    // Purpose: return the visible counter bits on a count read; all else reads zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && bus_addr == CNT_OFS)
            bus_rdata[REG_W-1:0] = count[CNT_W-1:FRAC_W];
    end

endmodule

// File: rtl/cmd_watchdog_checker.sv
// Module: cmd_watchdog_checker
// Temporal checks on the watchdog, bound into the top module.
module cmd_watchdog_checker #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 20,
    parameter int FRAC_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  count,
    input logic              running,
    input logic              unlocked,
    input logic              irq,
    input logic              rst_req
);

    logic cnt_wr;
    logic ctl_wr;
    logic upper_set;
    always_comb begin
        cnt_wr    = bus_sel && bus_wr && bus_addr == ADDR_W'(4);
        ctl_wr    = bus_sel && bus_wr && bus_addr == ADDR_W'(0);
        upper_set = |bus_wdata[DATA_W-1:16];
    end

    // R5: a closed count register keeps its value unless a tick could move it
    assert_locked_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !unlocked && !(running && tick_en)) |=> $stable(count));

    // R6: an accepted count write places the data in bits 19:4 and zeroes 3:0
    assert_load_placement_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && unlocked) |=>
        (count[FRAC_W-1:0] == '0 && count[CNT_W-1:FRAC_W] == $past(bus_wdata[CNT_W-FRAC_W-1:0])));

    // R4: a stopped counter does not move without a bus write
    assert_stopped_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !bus_sel) |=> $stable(count));

    // R9: a reset request only appears together with the interrupt flag
    assert_expiry_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> irq);

    // R9: a counter at zero stays there until a bus write
    assert_hold_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !bus_sel) |=> count == '0);

    // R3: a halt word with nonzero upper bits still stops the countdown
    assert_upper_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && upper_set && bus_wdata[15:0] == 16'h3877) |=> !running);

    // R10: an acknowledge with no tick in flight leaves the interrupt low
    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[15:0] == 16'h7482 && !tick_en) |=> !irq);

endmodule

bind cmd_watchdog cmd_watchdog_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .count    (count),
    .running  (running),
    .unlocked (unlocked),
    .irq      (irq),
    .rst_req  (rst_req)
);

// File: tb/cmd_watchdog_test.sv
// Bench: a vector table walked by one loop, then directed reset and corner tests.
module cmd_watchdog_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cmd_watchdog uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    // Vector: {op[1:0], addr[3:0], data[31:0], expected[15:0]}
    // op 0 = bus write, 1 = data ticks, 2 = count read compared with expected
    localparam int NV = 19;
    localparam logic [53:0] VEC [NV] = '{
        {2'd0, 4'h0, 32'h0000AB00, 16'h0000},   // R5 open
        {2'd0, 4'h4, 32'h00000003, 16'h0000},   // R6 load 0x30
        {2'd2, 4'h4, 32'h0,        16'h0003},   // R6 R2
        {2'd0, 4'h0, 32'h00004A4B, 16'h0000},   // R4 resume
        {2'd1, 4'h0, 32'd16,       16'h0000},   // R8 16 ticks
        {2'd2, 4'h4, 32'h0,        16'h0002},   // R8
        {2'd0, 4'h0, 32'h00003877, 16'h0000},   // R4 halt
        {2'd1, 4'h0, 32'd5,        16'h0000},
        {2'd2, 4'h4, 32'h0,        16'h0002},   // R4 frozen
        {2'd0, 4'h0, 32'h1234AB01, 16'h0000},   // R3 close with upper bits set
        {2'd0, 4'h4, 32'h00000100, 16'h0000},   // R5 ignored write
        {2'd2, 4'h4, 32'h0,        16'h0002},   // R5
        {2'd0, 4'h0, 32'h00001111, 16'h0000},   // R3 junk word
        {2'd2, 4'h4, 32'h0,        16'h0002},   // R3
        {2'd0, 4'h0, 32'h0000DEAF, 16'h0000},   // R7 refill while closed
        {2'd2, 4'h4, 32'h0,        16'hFFFF},   // R7
        {2'd0, 4'h0, 32'h0000AB00, 16'h0000},
        {2'd0, 4'h4, 32'h00000050, 16'h0000},
        {2'd2, 4'h4, 32'h0,        16'h0050}    // R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [3:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    // Same-cycle bus write and tick
    task automatic bwr_tick(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][53:52])
                2'd0: bwr(VEC[i][51:48], VEC[i][47:16]);
                2'd1: ticks(int'(VEC[i][47:16]));
                default: begin
                    brd(VEC[i][51:48], v);
                    check($sformatf("vector %0d", i), v, {16'h0, VEC[i][15:0]});
                end
            endcase
        end
        // R8: resume and take 8 ticks from 0x500 -> 0x4F8
        bwr(4'h0, 32'h4A4B);
        ticks(8);
        brd(4'h4, v); check("R8 decrement", v, 32'h004F);

        // R1: reset state
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        brd(4'h4, v); check("R1 count", v, 32'hFFFF);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 rst_req", {31'h0, rst_req}, 32'h0);
        ticks(3);
        brd(4'h4, v); check("R1 stopped", v, 32'hFFFF);
        bwr(4'h4, 32'h0007);
        brd(4'h4, v); check("R1 locked", v, 32'hFFFF);
        brd(4'h0, v); check("R2 ctrl reads zero", v, 32'h0);

        // R9: count of one expires on the 16th tick
        bwr(4'h0, 32'hAB00);
        bwr(4'h4, 32'h0001);
        bwr(4'h0, 32'hAB01);
        bwr(4'h0, 32'h4A4B);
        ticks(15);
        check("R9 no early irq", {31'h0, irq}, 32'h0);
        ticks(1);
        check("R9 irq", {31'h0, irq}, 32'h1);
        check("R9 rst_req", {31'h0, rst_req}, 32'h1);
        ticks(3);
        brd(4'h4, v); check("R9 hold zero", v, 32'h0);

        // R10: acknowledge clears irq only
        bwr(4'h0, 32'h7482);
        check("R10 irq cleared", {31'h0, irq}, 32'h0);
        check("R10 rst_req kept", {31'h0, rst_req}, 32'h1);
        bwr(4'h0, 32'hDEAF);
        check("R7 rst_req dropped", {31'h0, rst_req}, 32'h0);
        brd(4'h4, v); check("R7 refill", v, 32'hFFFF);

        // R11: expiry and acknowledge in the same cycle
        bwr(4'h0, 32'hAB00);
        bwr(4'h4, 32'h0001);
        ticks(15);
        bwr_tick(4'h0, 32'h7482);
        check("R11 expiry beats ack", {31'h0, irq}, 32'h1);
        check("R11 rst_req", {31'h0, rst_req}, 32'h1);

        // R11: count load and tick in the same cycle
        bwr_tick(4'h4, 32'h0002);
        brd(4'h4, v); check("R11 load beats tick", v, 32'h0002);
        check("R6 load drops rst_req", {31'h0, rst_req}, 32'h0);
        ticks(16);
        brd(4'h4, v); check("R8 after load", v, 32'h0001);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule